// File: doc/BRIEF.md
# Byte-Wide Host Mailbox Port (Strobe/Read-Write Bus Style)

This block sits between an external microprocessor and an internal signal-processing core. Each side passes single bytes to the other through it. On the host side the bus has an active-low select, an active-low data strobe, a read/write direction line, a small register address and an 8-bit data bus. The data bus is modelled as separate input, output and output-enable signals. An access exists only while select and strobe are both low. The host may tie the two together, or it may drive them separately and end a cycle early with whichever one rises first.

Every host input passes through a multi-stage synchroniser into the single system clock. The end of an access is detected once in the clock domain. On that one event, a write lands in the addressed register, or a read of the message register retires the outbound byte. Two flags form the handshake. The outbound-ready flag rises when the core posts a byte and falls once the host has read it. The inbound-busy flag rises when the host writes a byte and falls when the core acknowledges it.

Top module: `host_mailbox_port`

## Requirements
- R1: An access is seen only while `hst_sel_n` and `hst_stb_n` are both low. With either one high, the bus output enable stays low and no register is written.
- R2: `hst_doe` is high only while an access is seen with `hst_rd_wr` high (1 = read). It falls within SYNC_STAGES+1 clocks after either `hst_sel_n` or `hst_stb_n` returns high, even if the other stays low. While `hst_doe` is low, `hst_dout` is zero.
- R3: A write stores the data and address present when the first of select or strobe returns high. A data change after that instant has no effect, and each access produces exactly one capture.
- R4: A `core_tx_we` pulse loads `core_tx_data` into the outbound message register and sets `core_tx_full`. The flag reads back as bit 0 of the status register at address 1.
- R5: A host read at address 0 returns the outbound byte. `core_tx_full` clears after that access ends.
- R6: A host write at address 0 loads `core_rx_data` and sets `core_rx_full`, which reads back as bit 1 at address 1. A `core_rx_ack` pulse clears it.
- R7: A host write at address 0 while `core_rx_full` is set replaces the byte, and the flag stays set.
- R8: Addresses 2 and 3 read as zero. Host writes to addresses 1, 2 and 3 change nothing. Unused status bits read as zero.
- R9: After reset both flags are clear, `hst_doe` is low and the status register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_sel_n | input | 1 | Host chip select, active low |
| hst_stb_n | input | 1 | Host data strobe, active low |
| hst_rd_wr | input | 1 | Direction: 1 read, 0 write |
| hst_addr | input | 2 | Register address |
| hst_din | input | 8 | Host write data |
| hst_dout | output | 8 | Host read data |
| hst_doe | output | 1 | Output enable for the host data bus |
| core_tx_we | input | 1 | Core posts an outbound byte |
| core_tx_data | input | 8 | Outbound byte from the core |
| core_rx_data | output | 8 | Inbound byte for the core |
| core_rx_ack | input | 1 | Core has taken the inbound byte |
| core_tx_full | output | 1 | Outbound byte waiting for the host |
| core_rx_full | output | 1 | Inbound byte waiting for the core |

## Verification
The message path is exercised in both directions under three strobe patterns:
- Select and strobe asserted and released together, as when the two are tied.
- Select held low while only the strobe pulses, which shows that the two are combined by AND rather than either one alone starting an access.
- Strobe released while select stays low with the data then changing, which shows whether capture happens at the first rising edge or later, and whether the second edge captures a second time.

Reads of the status register between these steps show when each flag rises and clears. Writes and reads at the unused addresses show that they leave both messages untouched.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

   typedef enum logic [1:0] {
      HMB_MSG  = 2'd0,
      HMB_STAT = 2'd1,
      HMB_RSV2 = 2'd2,
      HMB_RSV3 = 2'd3
   } hmb_reg_e;

   localparam int HMB_TX_BIT = 0;
   localparam int HMB_RX_BIT = 1;

endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
   parameter int              WIDTH     = 1,
   parameter int              STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hmb_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RESET_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RESET_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hmb_access.sv
module hmb_access #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_s,
   input  logic              stb_n_s,
   input  logic              rd_wr_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] din_s,
   output logic              live,
   output logic              drive_en,
   output logic              acc_end,
   output logic              wr_evt,
   output logic              rd_evt,
   output logic [ADDR_W-1:0] evt_addr,
   output logic [DATA_W-1:0] evt_data
);

   logic live_q;

   // combined access strobe: both active-low inputs must be low
   assign live     = ~sel_n_s & ~stb_n_s;
   assign drive_en = live & rd_wr_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= live;
   end

   // the synced address and data line up with the synced strobes, so at this
   // cycle they carry the values present when the first strobe rose
   assign acc_end  = live_q & ~live;
   assign wr_evt   = acc_end & ~rd_wr_s;
   assign rd_evt   = acc_end &  rd_wr_s;
   assign evt_addr = addr_s;
   assign evt_data = din_s;

endmodule

// File: rtl/hmb_regs.sv
module hmb_regs
   import hmb_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_tx_we,
   input  logic [DATA_W-1:0] core_tx_data,
   input  logic              core_rx_ack,
   input  logic              wr_evt,
   input  logic              rd_evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [DATA_W-1:0] evt_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] core_rx_data,
   output logic              tx_full,
   output logic              rx_full
);

   localparam logic [ADDR_W-1:0] A_MSG  = ADDR_W'(HMB_MSG);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(HMB_STAT);

   logic [DATA_W-1:0] tx_msg;
   logic [DATA_W-1:0] rx_msg;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] mux_out;
   logic              host_wr_msg;
   logic              host_rd_msg;

   assign host_wr_msg = wr_evt & (evt_addr == A_MSG);
   assign host_rd_msg = rd_evt & (evt_addr == A_MSG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_msg  <= '0;
         tx_full <= 1'b0;
      end else if (core_tx_we) begin
         tx_msg  <= core_tx_data;
         tx_full <= 1'b1;
      end else if (host_rd_msg) begin
         tx_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_msg  <= '0;
         rx_full <= 1'b0;
      end else if (host_wr_msg) begin
         rx_msg  <= evt_data;
         rx_full <= 1'b1;
      end else if (core_rx_ack) begin
         rx_full <= 1'b0;
      end
   end

   assign core_rx_data = rx_msg;

   always_comb begin
      stat_word             = '0;
      stat_word[HMB_TX_BIT] = tx_full;
      stat_word[HMB_RX_BIT] = rx_full;
   end

   always_comb begin
      if (rd_addr == A_MSG)       mux_out = tx_msg;
      else if (rd_addr == A_STAT) mux_out = stat_word;
      else                        mux_out = '0;
   end

   if (READ_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= mux_out;
      end
      assign rdata = rdata_q;
   end else begin : g_rd_comb
      assign rdata = mux_out;
   end

endmodule

// File: rtl/host_mailbox_port.sv
module host_mailbox_port #(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit READ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel_n,
   input  logic              hst_stb_n,
   input  logic              hst_rd_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [DATA_W-1:0] hst_din,
   output logic [DATA_W-1:0] hst_dout,
   output logic              hst_doe,
   input  logic              core_tx_we,
   input  logic [DATA_W-1:0] core_tx_data,
   output logic [DATA_W-1:0] core_rx_data,
   input  logic              core_rx_ack,
   output logic              core_tx_full,
   output logic              core_rx_full
);

   localparam int CTL_W = 3;
   localparam int BUS_W = ADDR_W + DATA_W;

   if (ADDR_W < 2)      begin : g_chk_addr  $error("ADDR_W must be at least 2"); end
   if (DATA_W < 2)      begin : g_chk_data  $error("DATA_W must hold both flags"); end
   if (SYNC_STAGES > 4) begin : g_chk_sync  $error("SYNC_STAGES above 4 not supported"); end

   logic [CTL_W-1:0]  ctl_s;
   logic [BUS_W-1:0]  bus_s;
   logic              live_w, drive_w, acc_end_w, wr_evt_w, rd_evt_w;
   logic [ADDR_W-1:0] evt_addr_w;
   logic [DATA_W-1:0] evt_data_w, rdata_w;

   hmb_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL({CTL_W{1'b1}})) u_sync_ctl (
      .clk(clk), .rst_n(rst_n),
      .d({hst_sel_n, hst_stb_n, hst_rd_wr}), .q(ctl_s));

   hmb_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL({BUS_W{1'b0}})) u_sync_bus (
      .clk(clk), .rst_n(rst_n),
      .d({hst_addr, hst_din}), .q(bus_s));

   hmb_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .sel_n_s(ctl_s[2]), .stb_n_s(ctl_s[1]), .rd_wr_s(ctl_s[0]),
      .addr_s(bus_s[BUS_W-1:DATA_W]), .din_s(bus_s[DATA_W-1:0]),
      .live(live_w), .drive_en(drive_w), .acc_end(acc_end_w),
      .wr_evt(wr_evt_w), .rd_evt(rd_evt_w),
      .evt_addr(evt_addr_w), .evt_data(evt_data_w));

   hmb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_REG(READ_REG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .core_tx_we(core_tx_we), .core_tx_data(core_tx_data), .core_rx_ack(core_rx_ack),
      .wr_evt(wr_evt_w), .rd_evt(rd_evt_w),
      .evt_addr(evt_addr_w), .evt_data(evt_data_w),
      .rd_addr(bus_s[BUS_W-1:DATA_W]), .rdata(rdata_w),
      .core_rx_data(core_rx_data), .tx_full(core_tx_full), .rx_full(core_rx_full));

   assign hst_doe  = drive_w;
   assign hst_dout = drive_w ? rdata_w : '0;

endmodule

// File: rtl/hmb_checker.sv
module hmb_checker #(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_sel_n,
   input logic              hst_stb_n,
   input logic              hst_rd_wr,
   input logic [DATA_W-1:0] hst_dout,
   input logic              hst_doe,
   input logic              core_tx_we,
   input logic              core_rx_ack,
   input logic              core_tx_full,
   input logic              core_rx_full,
   input logic              acc_end,
   input logic              host_rd_msg,
   input logic              host_wr_msg
);

   // R2: bus is driven only for a read access seen through the synchroniser
   p_doe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hst_doe |-> $past(!hst_sel_n && !hst_stb_n && hst_rd_wr, SYNC_STAGES));

   // R2: undriven bus reads zero
   p_dout_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hst_doe |-> (hst_dout == '0));

   // R3: a single end event per access
   p_one_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_end |=> !acc_end);

   // R4: a core post sets the outbound flag
   p_tx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_tx_we |=> core_tx_full);

   // R5: outbound flag only falls after a host read of the message register
   p_tx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_tx_full) |-> $past(host_rd_msg));

   // R6: inbound flag only rises after a host write of the message register
   p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rx_full) |-> $past(host_wr_msg));

   // R7: inbound flag holds until acknowledged
   p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rx_full && !core_rx_ack) |=> core_rx_full);

endmodule

bind host_mailbox_port hmb_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .hst_sel_n(hst_sel_n), .hst_stb_n(hst_stb_n), .hst_rd_wr(hst_rd_wr),
   .hst_dout(hst_dout), .hst_doe(hst_doe),
   .core_tx_we(core_tx_we), .core_rx_ack(core_rx_ack),
   .core_tx_full(core_tx_full), .core_rx_full(core_rx_full),
   .acc_end(acc_end_w),
   .host_rd_msg(rd_evt_w && (evt_addr_w == '0)),
   .host_wr_msg(wr_evt_w && (evt_addr_w == '0))
);

// File: tb/sim_host_mailbox_port.sv
module sim_host_mailbox_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_sel_n = 1'b1, hst_stb_n = 1'b1, hst_rd_wr = 1'b1;
   logic [1:0] hst_addr = '0;
   logic [7:0] hst_din = '0;
   logic [7:0] hst_dout;
   logic       hst_doe;
   logic       core_tx_we = 1'b0, core_rx_ack = 1'b0;
   logic [7:0] core_tx_data = '0;
   logic [7:0] core_rx_data;
   logic       core_tx_full, core_rx_full;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   host_mailbox_port u0 (.*);

   // op: 0 core post, 1 host write, 2 host read+expect, 3 core take+expect
   localparam logic [19:0] VEC [18] = '{
      {2'd2, 2'd1, 8'h00, 8'h00},   // R9 status clear
      {2'd0, 2'd0, 8'hA5, 8'h00},   // R4 post
      {2'd2, 2'd1, 8'h00, 8'h01},   // R4 tx flag bit0
      {2'd2, 2'd0, 8'h00, 8'hA5},   // R5 read message
      {2'd2, 2'd1, 8'h00, 8'h00},   // R5 flag cleared
      {2'd1, 2'd0, 8'h3C, 8'h00},   // R6 host write
      {2'd2, 2'd1, 8'h00, 8'h02},   // R6 rx flag bit1
      {2'd3, 2'd0, 8'h00, 8'h3C},   // R6 core take
      {2'd2, 2'd1, 8'h00, 8'h00},   // R6 flag cleared
      {2'd1, 2'd2, 8'hFF, 8'h00},   // R8 write addr2
      {2'd2, 2'd2, 8'h00, 8'h00},   // R8 addr2 zero
      {2'd2, 2'd3, 8'h00, 8'h00},   // R8 addr3 zero
      {2'd1, 2'd1, 8'hFF, 8'h00},   // R8 write status
      {2'd2, 2'd1, 8'h00, 8'h00},   // R8 status unchanged
      {2'd1, 2'd0, 8'h11, 8'h00},   // R7 first byte
      {2'd1, 2'd0, 8'h22, 8'h00},   // R7 overwrite
      {2'd2, 2'd1, 8'h00, 8'h02},   // R7 still busy
      {2'd3, 2'd0, 8'h00, 8'h22}    // R7 newest byte
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); hst_rd_wr = 1'b0; hst_addr = a; hst_din = d;
      @(negedge clk); hst_sel_n = 1'b0; hst_stb_n = 1'b0;
      repeat (4) @(negedge clk);
      hst_sel_n = 1'b1; hst_stb_n = 1'b1;
      repeat (4) @(negedge clk);
      hst_rd_wr = 1'b1;
   endtask

   task automatic host_read(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); hst_rd_wr = 1'b1; hst_addr = a;
      @(negedge clk); hst_sel_n = 1'b0; hst_stb_n = 1'b0;
      repeat (4) @(negedge clk);
      check(req, {7'd0, hst_doe}, 8'h01);
      check(req, hst_dout, exp);
      hst_sel_n = 1'b1; hst_stb_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic core_post(input logic [7:0] d);
      @(negedge clk); core_tx_we = 1'b1; core_tx_data = d;
      @(negedge clk); core_tx_we = 1'b0;
   endtask

   task automatic core_take(input logic [7:0] exp, input string req);
      @(negedge clk);
      check(req, core_rx_data, exp);
      check(req, {7'd0, core_rx_full}, 8'h01);
      core_rx_ack = 1'b1;
      @(negedge clk); core_rx_ack = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state at the ports
      check("R9", {6'd0, core_tx_full, core_rx_full}, 8'h00);
      check("R9", {7'd0, hst_doe}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 18; i++) begin
         logic [1:0] op, a;
         logic [7:0] d, e;
         {op, a, d, e} = VEC[i];
         case (op)
            2'd0: core_post(d);
            2'd1: host_write(a, d);
            2'd2: host_read(a, e, $sformatf("vec%0d R4-R9 table", i));
            default: core_take(e, $sformatf("vec%0d R6/R7 take", i));
         endcase
      end

      // R1: strobe low with select high -> no drive, no write
      @(negedge clk); hst_rd_wr = 1'b1; hst_stb_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R1 read", {7'd0, hst_doe}, 8'h00);
      hst_rd_wr = 1'b0; hst_addr = 2'd0; hst_din = 8'h77;
      repeat (5) @(negedge clk);
      hst_stb_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 write", {7'd0, core_rx_full}, 8'h00);
      hst_rd_wr = 1'b1;

      // R1/R2: select held low, strobe alone pulses a read
      core_post(8'h5E);
      @(negedge clk); hst_sel_n = 1'b0; hst_addr = 2'd0;
      repeat (5) @(negedge clk);
      check("R1 sel only", {7'd0, hst_doe}, 8'h00);
      hst_stb_n = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 strobe read", hst_dout, 8'h5E);
      // R2: release by select alone while strobe stays low
      hst_sel_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R2 early release", {7'd0, hst_doe}, 8'h00);
      check("R2 quiet bus", hst_dout, 8'h00);
      hst_stb_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R5 cleared", {7'd0, core_tx_full}, 8'h00);

      // R3: capture at first rising strobe, exactly once
      @(negedge clk); hst_rd_wr = 1'b0; hst_addr = 2'd0; hst_din = 8'h5A;
      @(negedge clk); hst_sel_n = 1'b0; hst_stb_n = 1'b0;
      repeat (4) @(negedge clk);
      hst_stb_n = 1'b1;
      @(negedge clk); hst_din = 8'hC3;
      repeat (4) @(negedge clk);
      check("R3 capture value", core_rx_data, 8'h5A);
      check("R3 capture flag", {7'd0, core_rx_full}, 8'h01);
      core_rx_ack = 1'b1;
      @(negedge clk); core_rx_ack = 1'b0;
      hst_sel_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R3 single capture", {7'd0, core_rx_full}, 8'h00);
      check("R3 data kept", core_rx_data, 8'h5A);
      hst_rd_wr = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule